// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard Controller

This block tracks the instructions in a fetch, decode and execute pipeline and works out, every cycle, which stages may advance. Each instruction arrives as a decoded descriptor on a valid/ready stream. The descriptor carries a tag, branch flags (is-branch, delayed, taken), a register-transfer count for multi-register loads, and address-generator register read and write fields. The block holds each descriptor in its stage slot. From the slot contents it drives hold, bubble and flush signals and a fetch redirect, and it reports each instruction as it leaves execute.

A taken branch resolves while it sits in execute. When the branch is not delayed, the two younger slots are squashed, which costs three cycles in all. A not-taken branch costs one cycle. When the branch is delayed, the slots that follow it always complete. A multi-register load stays in execute for one cycle per register, and the younger stages wait. If decode reads an address-generator register that the instruction in execute is writing, decode waits one cycle and a bubble goes into execute.

Back-pressure on the input stream works as follows. A descriptor is taken on a clock edge where both `in_valid` and `in_ready` are high. While `in_ready` is low, the source must hold the descriptor steady. A cycle with `in_valid` low puts an empty slot into fetch. The retire output is a plain valid/tag pair with no back-pressure.

Top module: `hzc_pipe_ctrl`

## Requirements
- R1: While reset is applied and after it is released with no input, every slot is empty, `in_ready` is 1, and `ret_valid`, `redirect` and all hold and flush outputs are 0.
- R2: With no hazards, a descriptor accepted in cycle k is in fetch in k+1, in decode in k+2, and in execute in k+3, where it retires. Back-to-back descriptors retire in consecutive cycles and in order.
- R3: A taken branch with the delayed flag 0 raises `redirect` in the cycle it is in execute and squashes the decode and fetch slots (`flush_d`, `flush_f`). Squashed instructions never retire. The next accepted instruction retires 3 cycles after the branch.
- R4: A branch whose taken flag is 0 raises neither redirect nor flush. The instructions after it retire in the following cycles.
- R5: A taken branch with the delayed flag 1 raises `redirect` but keeps DELAY_SLOTS younger slots, counted from decode outward (default 2, so both are kept). The kept instructions retire.
- R6: If decode holds an instruction with the read flag set, execute holds a valid instruction with the write flag set, and the two 2-bit register indices are equal, then fetch and decode hold for exactly one cycle and `bubble_e` puts an empty slot into execute. Indices that differ cause no hold.
- R7: An instruction with transfer count c > 1 that is not a branch stays in execute for c cycles. It retires once, in the last of those cycles, and fetch and decode hold for c-1 cycles. A count of 0 or 1 takes one cycle.
- R8: When a squash and an address-generator interlock hit the same decode slot, the squash wins and no hold or bubble is raised.
- R9: `in_ready` is low in every cycle where fetch is held. A descriptor offered while `in_ready` is low is not taken, and it later retires exactly once. A cycle with no valid input retires nothing for that slot.
- R10: `redirect` is raised only for a valid branch in execute. The taken flag on an instruction that is not a branch has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Fetch slot can take a descriptor |
| in_tag | input | TAG_W | Instruction identifier |
| in_is_br | input | 1 | Instruction is a branch |
| in_br_dly | input | 1 | Branch uses delay slots |
| in_br_tkn | input | 1 | Branch resolves taken |
| in_xfer_cnt | input | CNT_W | Registers moved by a multi-register load |
| in_ag_wr | input | 1 | Writes an address-generator register |
| in_ag_wr_idx | input | AGEN_W | Index of the register written |
| in_ag_rd | input | 1 | Reads an address-generator register |
| in_ag_rd_idx | input | AGEN_W | Index of the register read |
| hold_f | output | 1 | Fetch slot held this cycle |
| hold_d | output | 1 | Decode slot held this cycle |
| bubble_e | output | 1 | Empty slot inserted into execute |
| flush_f | output | 1 | Fetch slot squashed |
| flush_d | output | 1 | Decode slot squashed |
| redirect | output | 1 | Fetch must switch to the branch target |
| redirect_tag | output | TAG_W | Tag of the redirecting branch |
| f_valid | output | 1 | Fetch slot occupied |
| f_tag | output | TAG_W | Fetch slot tag |
| d_valid | output | 1 | Decode slot occupied |
| d_tag | output | TAG_W | Decode slot tag |
| e_valid | output | 1 | Execute slot occupied |
| e_tag | output | TAG_W | Execute slot tag |
| ret_valid | output | 1 | Instruction completes this cycle |
| ret_tag | output | TAG_W | Tag of the completing instruction |

## Verification
The bench records the retire cycle of every tag and compares it with a timeline built from the requirements. A design that flushed too little would retire wrong-path tags, and one that flushed on a delayed branch would lose the delay-slot tags. An off-by-one load counter would shift every later retire by one cycle or retire the load twice. An interlock that matched on any index, or that ignored a pending squash, would add a bubble where none belongs. A design that treated the taken flag as valid on instructions that are not branches would redirect falsely.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int TAG_W  = 8;
  localparam int CNT_W  = 4;
  localparam int AGEN_W = 2;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic              is_br;
    logic              br_dly;
    logic              br_tkn;
    logic [CNT_W-1:0]  xfer_cnt;
    logic              ag_wr;
    logic [AGEN_W-1:0] ag_wr_idx;
    logic              ag_rd;
    logic [AGEN_W-1:0] ag_rd_idx;
  } instr_t;

  typedef struct packed {
    logic   vld;
    instr_t ins;
  } slot_t;
endpackage

// File: rtl/hzc_slot_reg.sv
module hzc_slot_reg
  import hzc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  slot_t nxt,
  output slot_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (!hold) q <= nxt;
  end
endmodule

// File: rtl/hzc_exec_stage.sv
module hzc_exec_stage
  import hzc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t nxt,
  output slot_t q,
  output logic  busy
);
  logic [CNT_W-1:0] extra_q;
  logic [CNT_W-1:0] extra_nxt;

  // extra cycles beyond the first; branches always take a single cycle
  always_comb begin
    extra_nxt = '0;
    if (nxt.vld && !nxt.ins.is_br && (nxt.ins.xfer_cnt > CNT_W'(1)))
      extra_nxt = nxt.ins.xfer_cnt - CNT_W'(1);
  end

  assign busy = q.vld && (extra_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q       <= '0;
      extra_q <= '0;
    end else if (busy) begin
      extra_q <= extra_q - CNT_W'(1);
    end else begin
      q       <= nxt;
      extra_q <= extra_nxt;
    end
  end
endmodule

// File: rtl/hzc_hazard_unit.sv
module hzc_hazard_unit
  import hzc_pkg::*;
#(
  parameter int DELAY_SLOTS = 2
) (
  input  logic              e_vld,
  input  logic              e_busy,
  input  logic              e_is_br,
  input  logic              e_dly,
  input  logic              e_tkn,
  input  logic              e_ag_wr,
  input  logic [AGEN_W-1:0] e_ag_wr_idx,
  input  logic              d_vld,
  input  logic              d_ag_rd,
  input  logic [AGEN_W-1:0] d_ag_rd_idx,
  output logic              redirect,
  output logic              flush_f,
  output logic              flush_d,
  output logic              ag_hold
);
  localparam bit KEEP_D = (DELAY_SLOTS >= 1);
  localparam bit KEEP_F = (DELAY_SLOTS >= 2);

  logic kill_d, kill_f;

  assign redirect = e_vld && !e_busy && e_is_br && e_tkn;

  generate
    if (KEEP_D) begin : g_keep_d
      assign kill_d = redirect && !e_dly;
    end else begin : g_kill_d
      assign kill_d = redirect;
    end
    if (KEEP_F) begin : g_keep_f
      assign kill_f = redirect && !e_dly;
    end else begin : g_kill_f
      assign kill_f = redirect;
    end
  endgenerate

  assign flush_d = kill_d;
  assign flush_f = kill_f;

  // squash has priority: a decode slot being flushed never interlocks
  assign ag_hold = !e_busy && e_vld && e_ag_wr && d_vld && d_ag_rd &&
                   (d_ag_rd_idx == e_ag_wr_idx) && !kill_d;
endmodule

// File: rtl/hzc_pipe_ctrl.sv
module hzc_pipe_ctrl
  import hzc_pkg::*;
#(
  parameter int DELAY_SLOTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic              in_is_br,
  input  logic              in_br_dly,
  input  logic              in_br_tkn,
  input  logic [CNT_W-1:0]  in_xfer_cnt,
  input  logic              in_ag_wr,
  input  logic [AGEN_W-1:0] in_ag_wr_idx,
  input  logic              in_ag_rd,
  input  logic [AGEN_W-1:0] in_ag_rd_idx,
  output logic              hold_f,
  output logic              hold_d,
  output logic              bubble_e,
  output logic              flush_f,
  output logic              flush_d,
  output logic              redirect,
  output logic [TAG_W-1:0]  redirect_tag,
  output logic              f_valid,
  output logic [TAG_W-1:0]  f_tag,
  output logic              d_valid,
  output logic [TAG_W-1:0]  d_tag,
  output logic              e_valid,
  output logic [TAG_W-1:0]  e_tag,
  output logic              ret_valid,
  output logic [TAG_W-1:0]  ret_tag
);
  localparam int FD_STAGES = 2;  // slot 0 = fetch, slot 1 = decode

  slot_t fd_nxt [FD_STAGES];
  slot_t fd_q   [FD_STAGES];
  logic  fd_hold[FD_STAGES];
  slot_t e_nxt, e_q;
  logic  e_busy, ag_hold;

  hzc_hazard_unit #(.DELAY_SLOTS(DELAY_SLOTS)) u_haz (
    .e_vld       (e_q.vld),
    .e_busy      (e_busy),
    .e_is_br     (e_q.ins.is_br),
    .e_dly       (e_q.ins.br_dly),
    .e_tkn       (e_q.ins.br_tkn),
    .e_ag_wr     (e_q.ins.ag_wr),
    .e_ag_wr_idx (e_q.ins.ag_wr_idx),
    .d_vld       (fd_q[1].vld),
    .d_ag_rd     (fd_q[1].ins.ag_rd),
    .d_ag_rd_idx (fd_q[1].ins.ag_rd_idx),
    .redirect    (redirect),
    .flush_f     (flush_f),
    .flush_d     (flush_d),
    .ag_hold     (ag_hold)
  );

  assign hold_d   = e_busy || ag_hold;
  assign hold_f   = hold_d;
  assign bubble_e = ag_hold;
  assign in_ready = !hold_f;

  // fetch takes the stream; decode takes fetch unless fetch is squashed
  always_comb begin
    fd_nxt[0].vld   = in_valid;
    fd_nxt[0].ins   = '{tag: in_tag, is_br: in_is_br, br_dly: in_br_dly,
                        br_tkn: in_br_tkn, xfer_cnt: in_xfer_cnt,
                        ag_wr: in_ag_wr, ag_wr_idx: in_ag_wr_idx,
                        ag_rd: in_ag_rd, ag_rd_idx: in_ag_rd_idx};
    fd_nxt[1].vld   = fd_q[0].vld && !flush_f;
    fd_nxt[1].ins   = fd_q[0].ins;
    fd_hold[0]      = hold_f;
    fd_hold[1]      = hold_d;
  end

  generate
    for (genvar s = 0; s < FD_STAGES; s++) begin : g_fd
      hzc_slot_reg u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (fd_hold[s]),
        .nxt   (fd_nxt[s]),
        .q     (fd_q[s])
      );
    end
  endgenerate

  always_comb begin
    e_nxt.ins = fd_q[1].ins;
    e_nxt.vld = fd_q[1].vld && !flush_d && !ag_hold;
  end

  hzc_exec_stage u_ex (
    .clk   (clk),
    .rst_n (rst_n),
    .nxt   (e_nxt),
    .q     (e_q),
    .busy  (e_busy)
  );

  assign f_valid      = fd_q[0].vld;
  assign f_tag        = fd_q[0].ins.tag;
  assign d_valid      = fd_q[1].vld;
  assign d_tag        = fd_q[1].ins.tag;
  assign e_valid      = e_q.vld;
  assign e_tag        = e_q.ins.tag;
  assign ret_valid    = e_q.vld && !e_busy;
  assign ret_tag      = e_q.ins.tag;
  assign redirect_tag = e_q.ins.tag;

  logic unused_e_bits;
  assign unused_e_bits = ^{e_q.ins.xfer_cnt, e_q.ins.ag_rd, e_q.ins.ag_rd_idx};
endmodule

// File: rtl/hzc_pipe_ctrl_chk.sv
module hzc_pipe_ctrl_chk
  import hzc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             hold_f,
  input logic             hold_d,
  input logic             bubble_e,
  input logic             flush_d,
  input logic             redirect,
  input logic             d_valid,
  input logic [TAG_W-1:0] d_tag,
  input logic             e_valid,
  input logic [TAG_W-1:0] e_tag,
  input logic             ret_valid
);
  p_flow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !hold_d && !flush_d) |=> (e_valid && e_tag == $past(d_tag)));

  p_squash_empties_ex_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_d |=> !e_valid);

  p_bubble_after_interlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_e |=> !e_valid);

  p_decode_stable_on_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hold_d |=> ($stable(d_tag) && $stable(d_valid)));

  p_no_retire_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_d && !bubble_e) |-> !ret_valid);

  p_flush_beats_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_d |-> !bubble_e);

  p_ready_low_when_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_f |-> !in_ready);

  p_redirect_from_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (e_valid && ret_valid));
endmodule

bind hzc_pipe_ctrl hzc_pipe_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .hold_f    (hold_f),
  .hold_d    (hold_d),
  .bubble_e  (bubble_e),
  .flush_d   (flush_d),
  .redirect  (redirect),
  .d_valid   (d_valid),
  .d_tag     (d_tag),
  .e_valid   (e_valid),
  .e_tag     (e_tag),
  .ret_valid (ret_valid)
);

// File: tb/tb_hzc_pipe_ctrl.sv
module tb_hzc_pipe_ctrl;
  import hzc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic in_valid = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic in_is_br = 0, in_br_dly = 0, in_br_tkn = 0, in_ag_wr = 0, in_ag_rd = 0;
  logic [CNT_W-1:0] in_xfer_cnt = '0;
  logic [AGEN_W-1:0] in_ag_wr_idx = '0, in_ag_rd_idx = '0;
  logic in_ready, hold_f, hold_d, bubble_e, flush_f, flush_d, redirect;
  logic f_valid, d_valid, e_valid, ret_valid;
  logic [TAG_W-1:0] redirect_tag, f_tag, d_tag, e_tag, ret_tag;

  hzc_pipe_ctrl dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_is_br(in_is_br), .in_br_dly(in_br_dly),
    .in_br_tkn(in_br_tkn), .in_xfer_cnt(in_xfer_cnt), .in_ag_wr(in_ag_wr),
    .in_ag_wr_idx(in_ag_wr_idx), .in_ag_rd(in_ag_rd), .in_ag_rd_idx(in_ag_rd_idx),
    .hold_f(hold_f), .hold_d(hold_d), .bubble_e(bubble_e), .flush_f(flush_f),
    .flush_d(flush_d), .redirect(redirect), .redirect_tag(redirect_tag),
    .f_valid(f_valid), .f_tag(f_tag), .d_valid(d_valid), .d_tag(d_tag),
    .e_valid(e_valid), .e_tag(e_tag), .ret_valid(ret_valid), .ret_tag(ret_tag)
  );

  int checks = 0, failures = 0, cyc_n = 0, t0 = 0;
  int ret_n = 0, red_n = 0, hold_n = 0, fl_n = 0, red_tag = 0;
  int ret_tag_log[32];
  int ret_cyc_log[32];

  always @(posedge clk) cyc_n <= cyc_n + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ret_valid && ret_n < 32) begin
        ret_tag_log[ret_n] = int'(ret_tag);
        ret_cyc_log[ret_n] = cyc_n;
        ret_n = ret_n + 1;
      end
      if (redirect) begin red_n = red_n + 1; red_tag = int'(redirect_tag); end
      if (hold_f) hold_n = hold_n + 1;
      if (flush_d) fl_n = fl_n + 1;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_ret(string req, int n, int tags[8], int offs[8]);
    chk(req, "retire count", ret_n, n);
    for (int i = 0; i < n && i < ret_n; i++) begin
      chk(req, $sformatf("tag of retire %0d", i), ret_tag_log[i], tags[i]);
      chk(req, $sformatf("cycle of tag %0d", tags[i]), ret_cyc_log[i] - t0, offs[i]);
    end
  endtask

  task automatic idle(int n);
    in_valid = 1'b0;
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic start();
    idle(6);
    ret_n = 0; red_n = 0; hold_n = 0; fl_n = 0; red_tag = 0;
    t0 = cyc_n;
  endtask

  task automatic send(int tag, bit br = 0, bit dly = 0, bit tkn = 0, int cnt = 1,
                      bit wr = 0, int widx = 0, bit rd = 0, int ridx = 0);
    bit acc;
    in_valid = 1'b1; in_tag = TAG_W'(tag); in_is_br = br; in_br_dly = dly;
    in_br_tkn = tkn; in_xfer_cnt = CNT_W'(cnt); in_ag_wr = wr;
    in_ag_wr_idx = AGEN_W'(widx); in_ag_rd = rd; in_ag_rd_idx = AGEN_W'(ridx);
    acc = 1'b0;
    while (!acc) begin
      acc = in_ready;
      @(negedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "in_ready in reset", int'(in_ready), 1);
    chk("R1", "slots in reset", int'({f_valid, d_valid, e_valid}), 0);
    chk("R1", "ret/redirect in reset", int'({ret_valid, redirect}), 0);
    #1 rst_n = 1'b1;
    idle(3);
    chk("R1", "slots after reset", int'({f_valid, d_valid, e_valid}), 0);
    chk("R1", "hold/flush after reset", int'({hold_f, hold_d, bubble_e, flush_f, flush_d}), 0);
  endtask

  task automatic t_steady();
    start();
    send(1); send(2); send(3); send(4);
    idle(6);
    expect_ret("R2", 4, '{1, 2, 3, 4, 0, 0, 0, 0}, '{3, 4, 5, 6, 0, 0, 0, 0});
  endtask

  task automatic t_nodelay_taken();
    start();
    send(10, 1, 0, 1); send(11); send(12); send(13);
    idle(6);
    expect_ret("R3", 2, '{10, 13, 0, 0, 0, 0, 0, 0}, '{3, 6, 0, 0, 0, 0, 0, 0});
    chk("R3", "redirect count", red_n, 1);
    chk("R3", "redirect tag", red_tag, 10);
    chk("R3", "flush cycles", fl_n, 1);
  endtask

  task automatic t_not_taken();
    start();
    send(20, 1, 0, 0); send(21); send(22);
    idle(6);
    expect_ret("R4", 3, '{20, 21, 22, 0, 0, 0, 0, 0}, '{3, 4, 5, 0, 0, 0, 0, 0});
    chk("R4", "redirect count", red_n, 0);
    chk("R4", "flush cycles", fl_n, 0);
  endtask

  task automatic t_delayed_taken();
    start();
    send(30, 1, 1, 1); send(31); send(32); send(33);
    idle(6);
    expect_ret("R5", 4, '{30, 31, 32, 33, 0, 0, 0, 0}, '{3, 4, 5, 6, 0, 0, 0, 0});
    chk("R5", "redirect count", red_n, 1);
    chk("R5", "flush cycles", fl_n, 0);
  endtask

  task automatic t_agen();
    start();
    send(40, 0, 0, 0, 1, 1, 1); send(41, 0, 0, 0, 1, 0, 0, 1, 1); send(42);
    send(43, 0, 0, 0, 1, 1, 2); send(44, 0, 0, 0, 1, 0, 0, 1, 3);
    idle(8);
    expect_ret("R6", 5, '{40, 41, 42, 43, 44, 0, 0, 0}, '{3, 5, 6, 7, 8, 0, 0, 0});
    chk("R6", "hold cycles", hold_n, 1);
  endtask

  task automatic t_ldm();
    start();
    send(50, 0, 0, 0, 3); send(51); send(52); send(53, 0, 0, 0, 0); send(54);
    idle(8);
    expect_ret("R7", 5, '{50, 51, 52, 53, 54, 0, 0, 0}, '{5, 6, 7, 8, 9, 0, 0, 0});
    chk("R7", "hold cycles", hold_n, 2);
  endtask

  task automatic t_flush_wins();
    start();
    send(60, 1, 0, 1, 1, 1, 1); send(61, 0, 0, 0, 1, 0, 0, 1, 1); send(62); send(63);
    idle(6);
    expect_ret("R8", 2, '{60, 63, 0, 0, 0, 0, 0, 0}, '{3, 6, 0, 0, 0, 0, 0, 0});
    chk("R8", "hold cycles", hold_n, 0);
  endtask

  task automatic t_gap();
    start();
    send(70); idle(1); send(71);
    idle(6);
    expect_ret("R9", 2, '{70, 71, 0, 0, 0, 0, 0, 0}, '{3, 5, 0, 0, 0, 0, 0, 0});
  endtask

  task automatic t_fake_taken();
    start();
    send(80, 0, 0, 1); send(81);
    idle(6);
    expect_ret("R10", 2, '{80, 81, 0, 0, 0, 0, 0, 0}, '{3, 4, 0, 0, 0, 0, 0, 0});
    chk("R10", "redirect count", red_n, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_steady();
    t_nodelay_taken();
    t_not_taken();
    t_delayed_taken();
    t_agen();
    t_ldm();
    t_flush_wins();
    t_gap();
    t_fake_taken();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule